// File: doc/BRIEF.md
# Exception Arbiter and Vector Address Generator

This block sits next to a small 8-bit processor core and chooses which exception the core services next. It also produces the pair of addresses from which the core reads the high and low bytes of the service routine's start address. There are two reset sources: an active-low pin and a request raised inside the chip. There is a software-interrupt strobe from the instruction decoder, an external request line, and a set of timer status flags, each with its own enable. Either reset source forces the reset vector onto the address outputs at once. Reset release is synchronised to the clock. After release, the block raises a single take pulse for the reset vector.

The block decides among the other sources only on an instruction-boundary strobe. At such a strobe the software interrupt wins over every hardware source and ignores the mask bit. The external request outranks the timer. All timer flags share one vector pair. Hardware sources are blocked while the core's mask bit, an input here, reads 1. When any source is taken, the block asserts a mask-set command so that nested hardware requests stay blocked. The core runs the software-interrupt strobe only when it executes that instruction. A hardware request that is pending at an earlier boundary is therefore taken there, before the instruction is fetched.

The vector slots are laid out in two-byte pairs above a base address, as slot = base + 2·index. Indices 0 to 3 are reserved and never chosen. Index 4 serves the timer, 5 the external request, 6 the software interrupt and 7 reset.

Top module: `exc_vector_sel`

## Requirements
- R1: While the pin `rst_pin_n` is 0 or `rst_req` is 1, the address outputs show the reset pair at once, with no clock needed. That pair is base+0xE for the high byte and base+0xF for the low byte.
- R2: While reset is active or being released, `take_o` is 0 and `mask_set_o` is 1.
- R3: After both reset sources go inactive, `take_o` pulses for exactly one cycle with the reset pair. The pulse comes on the (RST_SYNC+1)-th rising edge.
- R4: A boundary with `swi_i`=1 gives a take pulse with the pair base+0xC/base+0xD, whatever the value of `mask_i`.
- R5: A boundary with `ext_irq_i`=1, `mask_i`=0 and no software interrupt gives a take pulse with base+0xA/base+0xB.
- R6: A timer request is the OR over all bits of `tmr_flag_i` & `tmr_en_i`. A flag whose enable bit is 0 raises no request. An accepted timer request gives base+0x8/base+0x9, whichever flag caused it.
- R7: While `mask_i`=1, neither the external nor the timer request produces a take pulse.
- R8: Among requests present at one boundary, the order is software interrupt, then external, then timer.
- R9: `take_o` rises only in the cycle after a boundary strobe, or for the reset pulse. It stays high for one cycle.
- R10: `mask_set_o` is 1 in every cycle in which `take_o` is 1.
- R11: A take pulse never shows a reserved slot: the high-byte address always lies in base+0x8..base+0xE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_pin_n | input | 1 | External reset, active low, asynchronous assertion |
| rst_req | input | 1 | Internal reset request, active high |
| boundary_i | input | 1 | Instruction-boundary strobe |
| swi_i | input | 1 | Software-interrupt strobe from the decoder |
| ext_irq_i | input | 1 | External interrupt request, level |
| tmr_flag_i | input | N_TMR | Timer status flags (capture, compare, overflow) |
| tmr_en_i | input | N_TMR | Per-flag interrupt enables |
| mask_i | input | 1 | Interrupt mask bit of the condition code register |
| take_o | output | 1 | One-cycle request to start exception entry |
| vec_hi_o | output | 16 | Address of the vector's high byte |
| vec_lo_o | output | 16 | Address of the vector's low byte |
| mask_set_o | output | 1 | Command to set the mask bit |

## Verification
The bench builds the block with its default parameters. These are a base of 0x3FF0, three timer flags and a two-stage reset release, so every address it checks falls in 0x3FF8..0x3FFF. The two-stage release puts the reset take pulse on a known third edge, so the bench can check the release timing cycle by cycle. With three flags, each flag can be raised alone with its enable set and then with its enable cleared, which covers the shared timer slot.

// File: rtl/exc_vector_sel.sv
module exc_vector_sel #(
  parameter logic [15:0] VEC_BASE = 16'h3FF0,
  parameter int N_TMR    = 3,
  parameter int RST_SYNC = 2
) (
  input  logic             clk,
  input  logic             rst_pin_n,
  input  logic             rst_req,
  input  logic             boundary_i,
  input  logic             swi_i,
  input  logic             ext_irq_i,
  input  logic [N_TMR-1:0] tmr_flag_i,
  input  logic [N_TMR-1:0] tmr_en_i,
  input  logic             mask_i,
  output logic             take_o,
  output logic [15:0]      vec_hi_o,
  output logic [15:0]      vec_lo_o,
  output logic             mask_set_o
);
  localparam logic [1:0] SRC_TMR = 2'd0;
  localparam logic [1:0] SRC_EXT = 2'd1;
  localparam logic [1:0] SRC_SWI = 2'd2;
  localparam logic [1:0] SRC_RST = 2'd3;
  localparam logic [15:0] RST_HI = VEC_BASE | 16'h000E;

  logic                arst_n;
  logic [RST_SYNC-1:0] hold_q;
  logic                in_rst, boot_q, take_q;
  logic [1:0]          src_q, sel;
  logic                sel_vld, tmr_req, hw_ok;

  assign arst_n = rst_pin_n & ~rst_req;
  assign in_rst = hold_q[RST_SYNC-1];

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) hold_q <= '1;
    else         hold_q <= {hold_q[RST_SYNC-2:0], 1'b0};

  assign tmr_req = |(tmr_flag_i & tmr_en_i);
  assign hw_ok   = ~mask_i;

  always_comb begin
    sel_vld = 1'b1;
    if (swi_i)                  sel = SRC_SWI;
    else if (ext_irq_i && hw_ok) sel = SRC_EXT;
    else if (tmr_req && hw_ok)   sel = SRC_TMR;
    else begin sel = SRC_TMR; sel_vld = 1'b0; end
  end

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) begin
      take_q <= 1'b0; src_q <= SRC_RST; boot_q <= 1'b1;
    end else if (in_rst) begin
      take_q <= 1'b0; src_q <= SRC_RST; boot_q <= 1'b1;
    end else if (boot_q) begin
      take_q <= 1'b1; src_q <= SRC_RST; boot_q <= 1'b0;
    end else if (boundary_i && sel_vld) begin
      take_q <= 1'b1; src_q <= sel;
    end else begin
      take_q <= 1'b0;
    end

  assign take_o     = take_q;
  assign vec_hi_o   = VEC_BASE | {12'h000, 1'b1, src_q, 1'b0};
  assign vec_lo_o   = vec_hi_o | 16'h0001;
  assign mask_set_o = in_rst | boot_q | take_q;

  AST_RST_PULSE: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(in_rst) |=> take_o && vec_hi_o == RST_HI); // R3
  AST_SWI_UNMASKED: assert property (@(posedge clk) disable iff (!arst_n)
    (boundary_i && swi_i && !in_rst && !boot_q) |=> take_o && vec_hi_o == (VEC_BASE | 16'h000C)); // R4
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!arst_n)
    (boundary_i && mask_i && !swi_i && !in_rst && !boot_q) |=> !take_o); // R7
  AST_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!arst_n)
    (!boundary_i && !in_rst && !boot_q) |=> !take_o); // R9
  AST_NO_RESERVED: assert property (@(posedge clk) disable iff (!arst_n)
    take_o |-> vec_hi_o[3] && !vec_hi_o[0]); // R11
endmodule

// File: tb/exc_vector_sel_tb_top.sv
module exc_vector_sel_tb_top;
  logic clk = 0;
  always #2.5 clk = ~clk;

  logic rst_pin_n, rst_req, boundary_i, swi_i, ext_irq_i, mask_i;
  logic [2:0] tmr_flag_i, tmr_en_i;
  logic take_o, mask_set_o;
  logic [15:0] vec_hi_o, vec_lo_o;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  exc_vector_sel dut_i (.*);

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic idle();
    boundary_i = 0; swi_i = 0; ext_irq_i = 0; tmr_flag_i = 0; tmr_en_i = 0; mask_i = 0;
  endtask

  // one boundary with given sources; checks take and vector high address
  task automatic step(input string rq, input logic s, input logic e, input logic [2:0] f,
                      input logic [2:0] en, input logic m, input logic exp_take,
                      input logic [15:0] exp_hi);
    @(negedge clk);
    boundary_i = 1; swi_i = s; ext_irq_i = e; tmr_flag_i = f; tmr_en_i = en; mask_i = m;
    @(negedge clk);
    boundary_i = 0; swi_i = 0;
    chk(rq, take_o, exp_take);
    if (exp_take) begin
      chk(rq, vec_hi_o, exp_hi);
      chk(rq, vec_lo_o, exp_hi | 16'h1);
      chk("R10", mask_set_o, 1);
    end
    @(negedge clk);
    chk("R9", take_o, 0);
    idle();
  endtask

  task automatic t_reset(input bit use_pin);
    @(negedge clk);
    if (use_pin) rst_pin_n = 0; else rst_req = 1;
    #1;
    chk("R1", vec_hi_o, 16'h3FFE);
    chk("R1", vec_lo_o, 16'h3FFF);
    chk("R2", take_o, 0);
    chk("R2", mask_set_o, 1);
    @(negedge clk);
    rst_pin_n = 1; rst_req = 0;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      chk("R3", take_o, (i == 3));
      if (i < 3) chk("R2", mask_set_o, 1);
      if (i == 3) chk("R3", vec_hi_o, 16'h3FFE);
    end
  endtask

  task automatic t_no_boundary();
    @(negedge clk);
    ext_irq_i = 1; swi_i = 1; tmr_flag_i = 3'b111; tmr_en_i = 3'b111;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9", take_o, 0);
    end
    idle();
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_pin_n = 1; rst_req = 0; idle();
    t_reset(1);
    t_reset(0);
    step("R4", 1, 0, 0, 0, 1, 1, 16'h3FFC);
    step("R4", 1, 0, 0, 0, 0, 1, 16'h3FFC);
    step("R5", 0, 1, 0, 0, 0, 1, 16'h3FFA);
    step("R7", 0, 1, 0, 0, 1, 0, 16'h0);
    for (int b = 0; b < 3; b++) begin
      step("R6", 0, 0, 3'(1 << b), 3'(1 << b), 0, 1, 16'h3FF8);
      step("R6", 0, 0, 3'(1 << b), ~3'(1 << b), 0, 0, 16'h0);
    end
    step("R7", 0, 0, 3'b111, 3'b111, 1, 0, 16'h0);
    step("R8", 1, 1, 3'b111, 3'b111, 0, 1, 16'h3FFC);
    step("R8", 0, 1, 3'b001, 3'b001, 0, 1, 16'h3FFA);
    step("R8", 0, 1, 3'b010, 3'b010, 1, 0, 16'h0);
    t_no_boundary();
    step("R11", 0, 0, 3'b100, 3'b100, 0, 1, 16'h3FF8);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule